// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block sits behind a JTAG test access port on the target side. It gives an external debugger read and write access to a small file of debug registers: breakpoint value/control pairs, watchpoint value/control pairs and a vector-catch register. The TAP controller is not part of the block. It supplies one-cycle Capture, Shift and Update strobes that act as clock enables in the system clock domain, together with the serial input bit. The block drives the serial output bit.

Every scan carries one request: a write flag, a 32-bit data word and a 7-bit register address. Requests are pipelined by one scan. The bits captured at the start of a scan describe the most recently completed request, and the first bit reports Ready in place of the write flag. A request latched at Update takes a parameterised number of cycles to complete. If a scan captured Ready = 0, its Update is discarded and the host repeats the scan. To collect the result of its last real request, the host shifts a trailing dummy request (write, data 0, address 0).

Top module: `dbg_regchain`

## Requirements
- R1: The frame is 40 bits and is shifted least significant bit first, one bit per cycle in which shift is high. Bit 0 is the write flag (1 = write, 0 = read). Bits 1..32 are the data, LSB first. Bits 33..39 are the address, LSB first. The tdo output shows the bit that the next shift moves out.
- R2: On capture, bit 0 of the frame is loaded with Ready, bits 1..32 with the data of the most recently completed request, and bits 33..39 with its address.
- R3: A completed write stores the data in the addressed register. Its captured result carries the written value and the address.
- R4: A completed read returns the current contents of the addressed register and does not alter any register.
- R5: An Update is accepted only if the capture of the same scan reported Ready = 1. Any other Update is ignored: no register changes and no later result is affected.
- R6: An accepted request completes LATENCY cycles after its Update. Ready reads 0 until then, and a capture in that window returns the address and data of the request that completed before it.
- R7: Register map, all 32-bit read/write. Breakpoint value i is at 0x40+i and breakpoint control i at 0x50+i (i < NUM_BP). Watchpoint value i is at 0x60+i and watchpoint control i at 0x70+i (i < NUM_WP). The vector-catch register is at 0x07.
- R8: Address 0 and every address outside the map read as 0, and writes to them change no register.
- R9: After reset all registers are 0, Ready is 1, and the first capture returns address 0 and data 0.
- R10: A trailing dummy request (write flag 1, data 0, address 0) returns the result of the last real request and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| capture_dr | input | 1 | Capture strobe: load Ready and the previous result into the frame |
| shift_dr | input | 1 | Shift strobe: move the frame one bit toward tdo, taking in tdi |
| update_dr | input | 1 | Update strobe: latch the shifted frame as a new request |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the frame) |

## Verification
The bench builds the block with LATENCY = 48, which is longer than one full scan of 42 cycles. A scan that starts right after an accepted Update therefore always captures Ready = 0. This exercises the retry loop, the stale result fields in a busy capture, and the discarding of an Update whose scan saw Ready = 0. NUM_WP = 4 places the watchpoint pairs at 0x60..0x63 and 0x70..0x73, which leaves the gaps above them (such as 0x64) unmapped for the ignored-write checks. NUM_BP stays at 16 so that the full breakpoint bank is written, read back and cleared.

// File: rtl/dbg_regchain_pkg.sv
package dbg_regchain_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = 1 + DATA_W + ADDR_W;
    localparam int IDX_W   = 4;

    localparam logic [ADDR_W-1:0] VCATCH_ADDR = 7'h07;
    localparam logic [2:0]        BPV_PAGE    = 3'b100;
    localparam logic [2:0]        BPC_PAGE    = 3'b101;
    localparam logic [2:0]        WPV_PAGE    = 3'b110;
    localparam logic [2:0]        WPC_PAGE    = 3'b111;

    // Request as shifted in: write flag at bit 0, then data, then address
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr;
    } dbg_req_t;

    // Frame contents loaded at capture
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              ready;
    } dbg_cap_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_BPV,
        RK_BPC,
        RK_WPV,
        RK_WPC,
        RK_VCATCH
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef enum logic {
        ACC_IDLE,
        ACC_BUSY
    } acc_state_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int nbp, input int nwp);
        reg_sel_t s;
        s.idx  = a[IDX_W-1:0];
        s.kind = RK_NONE;
        if (a == VCATCH_ADDR) begin
            s.kind = RK_VCATCH;
        end else if (a[6:4] == BPV_PAGE && int'(a[3:0]) < nbp) begin
            s.kind = RK_BPV;
        end else if (a[6:4] == BPC_PAGE && int'(a[3:0]) < nbp) begin
            s.kind = RK_BPC;
        end else if (a[6:4] == WPV_PAGE && int'(a[3:0]) < nwp) begin
            s.kind = RK_WPV;
        end else if (a[6:4] == WPC_PAGE && int'(a[3:0]) < nwp) begin
            s.kind = RK_WPC;
        end
        return s;
    endfunction

endpackage

// File: rtl/dbg_shift_chain.sv
module dbg_shift_chain
    import dbg_regchain_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               tdi,
    input  dbg_cap_t           cap_in,
    output logic               tdo,
    output logic [FRAME_W-1:0] frame_out
);

    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture_dr) begin
            sr <= cap_in;
        end else if (shift_dr) begin
            sr <= {tdi, sr[FRAME_W-1:1]};
        end
    end

    assign tdo       = sr[0];
    assign frame_out = sr;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({capture_dr, shift_dr})); // R1

    AST_TDO_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!capture_dr && !shift_dr) |=> $stable(tdo)); // R1

endmodule

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
    import dbg_regchain_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_dr,
    input  logic              update_dr,
    input  dbg_req_t          frame_req,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] wr_data,
    output dbg_cap_t          cap_out
);

    localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    acc_state_t        state;
    dbg_req_t          req;
    logic [CNT_W-1:0]  cnt;
    logic              armed;
    logic              accept;
    logic              done;
    logic [ADDR_W-1:0] res_addr;
    logic [DATA_W-1:0] res_data;

    assign accept = update_dr && armed && (state == ACC_IDLE);
    assign done   = (state == ACC_BUSY) && (cnt == '0);

    // Remembers whether the capture of the current scan saw Ready
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (capture_dr) begin
            armed <= (state == ACC_IDLE);
        end else if (update_dr) begin
            armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ACC_IDLE;
            req   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ACC_IDLE: begin
                    if (accept) begin
                        req   <= frame_req;
                        cnt   <= CNT_LOAD;
                        state <= ACC_BUSY;
                    end
                end
                ACC_BUSY: begin
                    if (cnt == '0) begin
                        state <= ACC_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ACC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_addr <= '0;
            res_data <= '0;
        end else if (done) begin
            res_addr <= req.addr;
            res_data <= req.wr ? req.data : rd_data;
        end
    end

    assign wr_en    = done && req.wr;
    assign acc_addr = req.addr;
    assign wr_data  = req.data;

    always_comb begin
        cap_out.addr  = res_addr;
        cap_out.data  = res_data;
        cap_out.ready = (state == ACC_IDLE);
    end

    // Checker: consecutive busy cycles
    logic [CNT_W:0] busy_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
        end else if (state == ACC_BUSY) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        int'(busy_run) <= LATENCY); // R6

    AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == ACC_BUSY) |=> $stable(req)); // R5

    AST_START_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (state == ACC_IDLE) ##1 (state == ACC_BUSY) |-> $past(update_dr)); // R5

    AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(res_addr) && $stable(res_data))); // R6

endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file
    import dbg_regchain_pkg::*;
#(
    parameter int NUM_BP = 16,
    parameter int NUM_WP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    reg_sel_t          sel;
    logic [DATA_W-1:0] bpv [NUM_BP];
    logic [DATA_W-1:0] bpc [NUM_BP];
    logic [DATA_W-1:0] wpv [NUM_WP];
    logic [DATA_W-1:0] wpc [NUM_WP];
    logic [DATA_W-1:0] vcatch;

    assign sel = decode_addr(addr, NUM_BP, NUM_WP);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        always_ff @(posedge clk) begin
            if (rst) begin
                bpv[g] <= '0;
                bpc[g] <= '0;
            end else if (wr_en && sel.idx == IDX_W'(g)) begin
                if (sel.kind == RK_BPV) bpv[g] <= wr_data;
                if (sel.kind == RK_BPC) bpc[g] <= wr_data;
            end
        end
    end

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        always_ff @(posedge clk) begin
            if (rst) begin
                wpv[g] <= '0;
                wpc[g] <= '0;
            end else if (wr_en && sel.idx == IDX_W'(g)) begin
                if (sel.kind == RK_WPV) wpv[g] <= wr_data;
                if (sel.kind == RK_WPC) wpc[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vcatch <= '0;
        end else if (wr_en && sel.kind == RK_VCATCH) begin
            vcatch <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (sel.kind)
            RK_BPV:    rd_data = bpv[int'(sel.idx) % NUM_BP];
            RK_BPC:    rd_data = bpc[int'(sel.idx) % NUM_BP];
            RK_WPV:    rd_data = wpv[int'(sel.idx) % NUM_WP];
            RK_WPC:    rd_data = wpc[int'(sel.idx) % NUM_WP];
            RK_VCATCH: rd_data = vcatch;
            default:   rd_data = '0;
        endcase
    end

    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.kind == RK_NONE) |=>
        ($stable(vcatch) && $stable(bpv[0]) && $stable(bpc[0]) &&
         $stable(wpv[0]) && $stable(wpc[0]))); // R8

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(vcatch) && $stable(bpc[NUM_BP-1]))); // R4

endmodule

// File: rtl/dbg_regchain.sv
module dbg_regchain
    import dbg_regchain_pkg::*;
#(
    parameter int NUM_BP  = 16,
    parameter int NUM_WP  = 2,
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic tdi,
    output logic tdo
);

    logic [FRAME_W-1:0] frame;
    dbg_req_t           frame_req;
    dbg_cap_t           cap;
    logic               wr_en;
    logic [ADDR_W-1:0]  acc_addr;
    logic [DATA_W-1:0]  wr_data;
    logic [DATA_W-1:0]  rd_data;

    assign frame_req = dbg_req_t'(frame);

    dbg_shift_chain u_chain (
        .clk        (clk),
        .rst        (rst),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .cap_in     (cap),
        .tdo        (tdo),
        .frame_out  (frame)
    );

    dbg_access_ctrl #(
        .LATENCY (LATENCY)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .capture_dr (capture_dr),
        .update_dr  (update_dr),
        .frame_req  (frame_req),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .acc_addr   (acc_addr),
        .wr_data    (wr_data),
        .cap_out    (cap)
    );

    dbg_reg_file #(
        .NUM_BP (NUM_BP),
        .NUM_WP (NUM_WP)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (acc_addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    AST_WRITE_ECHO_MATCHES_REG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && decode_addr(acc_addr, NUM_BP, NUM_WP).kind != RK_NONE) |=>
        (rd_data == cap.data)); // R3

    AST_CAPTURE_LOADS_READY: assert property (@(posedge clk) disable iff (rst)
        capture_dr |=> (tdo == $past(cap.ready))); // R2

endmodule

// File: tb/dbg_regchain_tb.sv
module dbg_regchain_tb;

    localparam int NBP = 16;
    localparam int NWP = 4;
    localparam int LAT = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic capture_dr = 1'b0;
    logic shift_dr = 1'b0;
    logic update_dr = 1'b0;
    logic tdi = 1'b0;
    logic tdo;

    always #4 clk = ~clk;

    dbg_regchain #(
        .NUM_BP  (NBP),
        .NUM_WP  (NWP),
        .LATENCY (LAT)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_busy   = 0;
    logic finished = 1'b0;

    logic [31:0] model [128];
    logic [38:0] cap_q [$];
    logic [38:0] exp_q [$];
    string       tag_q [$];
    logic [38:0] last_fields;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Register map from R7
    function automatic bit is_mapped(input logic [6:0] a);
        if (a == 7'h07) return 1'b1;
        if (a[6:4] == 3'b100 || a[6:4] == 3'b101) return int'(a[3:0]) < NBP;
        if (a[6:4] == 3'b110 || a[6:4] == 3'b111) return int'(a[3:0]) < NWP;
        return 1'b0;
    endfunction

    // One full scan: capture, 40 shifts, update
    task automatic scan(input logic wr, input logic [6:0] addr, input logic [31:0] data,
                        output logic [39:0] cap);
        logic [39:0] frm;
        frm = {addr, data, wr};
        @(negedge clk);
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        for (int i = 0; i < 40; i++) begin
            shift_dr = 1'b1;
            tdi      = frm[i];
            cap[i]   = tdo;
            @(negedge clk);
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    // Driver: repeat a request until accepted, then push expectation
    task automatic issue(input logic wr, input logic [6:0] addr, input logic [31:0] data,
                         input string tag, output int tries);
        logic [39:0] cap;
        logic [31:0] exp_d;
        tries = 0;
        forever begin
            scan(wr, addr, data, cap);
            if (cap[0]) begin
                cap_q.push_back(cap[39:1]);
                exp_d = wr ? data : (is_mapped(addr) ? model[addr] : 32'h0);
                exp_q.push_back({addr, exp_d});
                tag_q.push_back(tag);
                if (wr && is_mapped(addr)) model[addr] = data;
                last_fields = cap[39:1];
                break;
            end
            n_busy++;
            check(cap[39:1] == last_fields, "R6 busy capture shows prior result",
                  64'(cap[39:1]), 64'(last_fields));
            tries++;
            if (tries > 8) begin
                check(1'b0, "R6 ready never returned", 64'(tries), 64'd0);
                break;
            end
        end
    endtask

    // Monitor: pair captured results with expectations
    initial begin
        logic [38:0] got;
        logic [38:0] want;
        string       t;
        forever begin
            @(negedge clk);
            while (cap_q.size() > 0 && exp_q.size() > 0) begin
                got  = cap_q.pop_front();
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                check(got == want, t, 64'(got), 64'(want));
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int          tr;
        logic [39:0] cap;
        for (int i = 0; i < 128; i++) model[i] = 32'h0;
        last_fields = '0;
        exp_q.push_back(39'h0);
        tag_q.push_back("R9 reset result fields zero");
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R9: first scan sees Ready without retry
        issue(1'b0, 7'h07, 32'h0, "R9 vector catch reset value", tr);
        check(tr == 0, "R9 ready after reset", 64'(tr), 64'd0);

        // R3 R7: fill breakpoints, watchpoints, vector catch
        for (int i = 0; i < NBP; i++) begin
            issue(1'b1, 7'(8'h40 + i), 32'hA500_0000 + 32'(i) * 32'h1111, "R3 bp value write", tr);
            issue(1'b1, 7'(8'h50 + i), 32'h5A00_0001 + 32'(i) * 32'h0202, "R3 bp control write", tr);
        end
        for (int i = 0; i < NWP; i++) begin
            issue(1'b1, 7'(8'h60 + i), 32'hC0DE_0000 + 32'(i), "R3 wp value write", tr);
            issue(1'b1, 7'(8'h70 + i), 32'h0000_F000 + 32'(i), "R3 wp control write", tr);
        end
        issue(1'b1, 7'h07, 32'h0000_001F, "R3 vector catch write", tr);

        // R4 R7: read back
        for (int i = 0; i < NBP; i++) begin
            issue(1'b0, 7'(8'h40 + i), 32'hFFFF_FFFF, "R4 R7 bp value read", tr);
            issue(1'b0, 7'(8'h50 + i), 32'h0, "R4 R7 bp control read", tr);
        end
        for (int i = 0; i < NWP; i++) begin
            issue(1'b0, 7'(8'h60 + i), 32'h0, "R4 R7 wp value read", tr);
            issue(1'b0, 7'(8'h70 + i), 32'h0, "R4 R7 wp control read", tr);
        end
        issue(1'b0, 7'h07, 32'h0, "R4 vector catch read", tr);
        issue(1'b0, 7'h07, 32'h0, "R4 second read unchanged", tr);

        // R8: address 0 and unmapped addresses
        issue(1'b1, 7'h3F, 32'hDEAD_BEEF, "R8 unmapped write echo", tr);
        issue(1'b1, 7'h64, 32'h1234_5678, "R8 unmapped wp slot write echo", tr);
        issue(1'b1, 7'h00, 32'h0BAD_0BAD, "R8 addr0 write echo", tr);
        issue(1'b0, 7'h3F, 32'h0, "R8 unmapped read zero", tr);
        issue(1'b0, 7'h64, 32'h0, "R8 unmapped wp slot read zero", tr);
        issue(1'b0, 7'h00, 32'h0, "R8 addr0 read zero", tr);
        issue(1'b0, 7'h63, 32'h0, "R8 neighbour intact", tr);

        // R5: scan right after acceptance sees Ready 0; its update is dropped
        issue(1'b1, 7'h53, 32'h0000_0333, "R5 setup write", tr);
        scan(1'b1, 7'h61, 32'hFEED_FACE, cap);
        check(cap[0] == 1'b0, "R5 busy scan ready bit", 64'(cap[0]), 64'd0);
        repeat (LAT + 4) @(negedge clk);
        issue(1'b0, 7'h61, 32'h0, "R5 dropped write had no effect", tr);
        check(tr == 0, "R6 ready after idle gap", 64'(tr), 64'd0);

        // R3: clearing controls and vector catch with zero writes
        for (int i = 0; i < NBP; i++)
            issue(1'b1, 7'(8'h50 + i), 32'h0, "R3 bp control clear", tr);
        issue(1'b1, 7'h07, 32'h0, "R3 vector catch clear", tr);
        issue(1'b0, 7'h50, 32'h0, "R3 bp control 0 cleared", tr);
        issue(1'b0, 7'h5F, 32'h0, "R3 bp control 15 cleared", tr);
        issue(1'b0, 7'h07, 32'h0, "R3 vector catch cleared", tr);

        // R10: trailing dummy collects the last result, then check no effect
        issue(1'b1, 7'h00, 32'h0, "R10 dummy request", tr);
        issue(1'b0, 7'h4A, 32'h0, "R10 dummy result", tr);
        issue(1'b1, 7'h00, 32'h0, "R10 register intact after dummy", tr);

        check(n_busy > 0, "R6 busy captures observed", 64'(n_busy), 64'd1);

        repeat (4) @(negedge clk);
        check(cap_q.size() == 0, "R2 all results compared", 64'(cap_q.size()), 64'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule